// File: doc/BRIEF.md
# Rotating priority interrupt resolver

This block is the decision core of an eight-input interrupt controller. Each input line feeds a request latch that works either on edges or on levels, chosen per input. The latched requests, less a mask, compete under a rotating priority: the input at the rotation base ranks highest, and rank falls as the index climbs modulo the input count. A candidate is raised to the processor only when it outranks every interrupt already in service.

The processor side acknowledges with a one-cycle strobe. The acknowledge moves the winning input into the in-service register. An end-of-interrupt command retires in-service bits later, either the highest-ranked one or a named one, and may also rotate the base. Automatic end-of-interrupt skips the in-service step and can rotate the base on each acknowledge. A fully nested option lets a master core ignore the in-service bit of its cascade input, so that further requests arriving through that input are not blocked.

Top module: `prio_irq_core`

## Requirements
- R1: Reset clears the request, in-service, mask and last-seen-level registers, sets the rotation base to 0 and drives `irq_req` low and `irq_idx` to 0.
- R2: On an edge input (`cfg_level` bit 0), the request bit is set only when the line is high and its last-seen level was low. A low line updates the last-seen level and leaves a latched request in place.
- R3: On a level input (`cfg_level` bit 1), the request bit takes the line value on every clock.
- R4: Rank of input i is (i − base) mod 8, where rank 0 is highest. The reported index `irq_idx` is the input number of the best-ranked unmasked request.
- R5: An interrupt is signalled only if the candidate's rank is strictly better than that of the best in-service bit, or if no bit is in service. `irq_req` and `irq_idx` are registered and show the state of the previous cycle. `irq_idx` is 0 while `irq_req` is low.
- R6: A set mask bit, loaded with `mask_we`/`mask_wdata`, keeps that input from winning. Its request bit still latches.
- R7: With `cfg_sfnm` and `cfg_master` both high, in-service bit 2 is ignored when the in-service rank is formed.
- R8: An acknowledge with an eligible winner sets that input's in-service bit. It clears the winner's request bit only on an edge input.
- R9: With `cfg_aeoi` high, an acknowledge leaves the in-service register unchanged. If `cfg_rot_aeoi` is also high, the base becomes (winner + 1) mod 8.
- R10: An acknowledge when no input is eligible changes no register.
- R11: A non-specific end-of-interrupt (`eoi_specific` low) clears the best-ranked in-service bit. With `eoi_rotate` high, the base becomes (that input + 1) mod 8. It does nothing when no bit is in service.
- R12: A specific end-of-interrupt clears in-service bit `eoi_sel`. With `eoi_rotate` high, the base becomes (`eoi_sel` + 1) mod 8.
- R13: When both are strobed in one cycle, a taken acknowledge wins and the end-of-interrupt is dropped. A `base_we` load overrides any rotation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 8 | Interrupt input lines |
| cfg_level | input | 8 | Per-input trigger mode, 1 = level, 0 = edge |
| cfg_aeoi | input | 1 | Automatic end-of-interrupt enable |
| cfg_rot_aeoi | input | 1 | Rotate base on automatic end-of-interrupt |
| cfg_sfnm | input | 1 | Special fully nested mode |
| cfg_master | input | 1 | This core is the cascade master |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 8 | Mask value, 1 = masked |
| base_we | input | 1 | Load the rotation base |
| base_wdata | input | 3 | Rotation base value |
| irq_ack | input | 1 | Acknowledge strobe |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_specific | input | 1 | 1 = clear `eoi_sel`, 0 = clear best-ranked |
| eoi_rotate | input | 1 | Rotate base after the clear |
| eoi_sel | input | 3 | Input for a specific end-of-interrupt |
| irq_req | output | 1 | Registered interrupt request |
| irq_idx | output | 3 | Registered winning input index |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| base_o | output | 3 | Rotation base |

## Verification
A wrong latch bit shows up on `irr_o` on the clock after the line changes. It then shows as a wrong `irq_req` or `irq_idx` one clock later, because the output stage adds one register. A base or in-service register that goes astray shows on `base_o` or `isr_o` at once. It also changes which input wins, and that appears on `irq_idx` one cycle after the error. So every internal fault is visible at the ports within two clocks.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned MAX_IN = 32;

  // First offset p (0..n-1) whose bit ((p + base) mod n) is set; n if none.
  function automatic int unsigned rot_scan(input logic [MAX_IN-1:0] m,
                                           input int unsigned base,
                                           input int unsigned n);
    int unsigned res;
    int unsigned pos;
    res = n;
    for (int p = MAX_IN - 1; p >= 0; p--) begin
      if (p < int'(n)) begin
        pos = int'(p) + base;
        if (pos >= n) pos = pos - n;
        if (m[pos]) res = p;
      end
    end
    return res;
  endfunction

  // (a + b) mod n for a, b below n.
  function automatic int unsigned wrap_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/prio_irq_latch.sv
module prio_irq_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] level_cfg,
  input  logic [N-1:0] clr_edge,
  output logic [N-1:0] irr
);
  logic [N-1:0] last_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise;
    assign rise = lines[i] & ~last_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q[i] <= 1'b0;
        irr[i]    <= 1'b0;
      end else begin
        last_q[i] <= lines[i];
        if (level_cfg[i]) irr[i] <= lines[i];
        else              irr[i] <= (irr[i] | rise) & ~clr_edge[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve
  import prio_irq_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned CASC  = 2,
  localparam int unsigned W    = $clog2(N)
) (
  input  logic [N-1:0] irr,
  input  logic [N-1:0] imr,
  input  logic [N-1:0] isr,
  input  logic [W-1:0] base,
  input  logic         sfnm,
  input  logic         master,
  output logic         win_valid,
  output logic [W-1:0] win_idx,
  output logic         top_valid,
  output logic [W-1:0] top_idx
);
  logic [N-1:0] cand_mask;
  logic [N-1:0] busy_mask;
  int unsigned  cand_p;
  int unsigned  cur_p;
  int unsigned  top_p;

  always_comb begin
    cand_mask = irr & ~imr;
    busy_mask = isr;
    if (sfnm && master && (CASC < N)) busy_mask[CASC] = 1'b0;
    cand_p    = rot_scan(MAX_IN'(cand_mask), 32'(base), N);
    cur_p     = rot_scan(MAX_IN'(busy_mask), 32'(base), N);
    top_p     = rot_scan(MAX_IN'(isr), 32'(base), N);
    win_valid = (cand_p < cur_p);
    win_idx   = W'(wrap_add(cand_p, 32'(base), N));
    top_valid = (top_p < N);
    top_idx   = W'(wrap_add(top_p, 32'(base), N));
  end
endmodule

// File: rtl/prio_irq_service.sv
module prio_irq_service
  import prio_irq_pkg::*;
#(
  parameter int unsigned N  = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ack_take,
  input  logic [W-1:0] win_idx,
  input  logic         aeoi,
  input  logic         rot_aeoi,
  input  logic         eoi_take,
  input  logic         eoi_specific,
  input  logic         eoi_rotate,
  input  logic [W-1:0] eoi_sel,
  input  logic         top_valid,
  input  logic [W-1:0] top_idx,
  input  logic         base_we,
  input  logic [W-1:0] base_wdata,
  output logic [N-1:0] isr,
  output logic [W-1:0] base
);
  logic         eoi_hit;
  logic [W-1:0] eoi_tgt;

  assign eoi_hit = eoi_take & (eoi_specific | top_valid);
  assign eoi_tgt = eoi_specific ? eoi_sel : top_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr  <= '0;
      base <= '0;
    end else begin
      if (ack_take) begin
        if (!aeoi)         isr[win_idx] <= 1'b1;
        else if (rot_aeoi) base <= W'(wrap_add(32'(win_idx), 1, N));
      end else if (eoi_hit) begin
        isr[eoi_tgt] <= 1'b0;
        if (eoi_rotate) base <= W'(wrap_add(32'(eoi_tgt), 1, N));
      end
      if (base_we) base <= base_wdata;
    end
  end
endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core #(
  parameter int unsigned N    = 8,
  parameter int unsigned CASC = 2,
  localparam int unsigned W   = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_lines,
  input  logic [N-1:0] cfg_level,
  input  logic         cfg_aeoi,
  input  logic         cfg_rot_aeoi,
  input  logic         cfg_sfnm,
  input  logic         cfg_master,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         base_we,
  input  logic [W-1:0] base_wdata,
  input  logic         irq_ack,
  input  logic         eoi_valid,
  input  logic         eoi_specific,
  input  logic         eoi_rotate,
  input  logic [W-1:0] eoi_sel,
  output logic         irq_req,
  output logic [W-1:0] irq_idx,
  output logic [N-1:0] irr_o,
  output logic [N-1:0] isr_o,
  output logic [W-1:0] base_o
);
  logic [N-1:0] imr_q;
  logic         win_valid;
  logic [W-1:0] win_idx;
  logic         top_valid;
  logic [W-1:0] top_idx;
  logic         ack_take;
  logic         eoi_take;
  logic [N-1:0] clr_edge;

  assign ack_take = irq_ack & win_valid;
  assign eoi_take = eoi_valid & ~ack_take;

  always_comb begin
    clr_edge = '0;
    if (ack_take) clr_edge[win_idx] = ~cfg_level[win_idx];
  end

  prio_irq_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .level_cfg(cfg_level),
    .clr_edge(clr_edge), .irr(irr_o)
  );

  prio_irq_resolve #(.N(N), .CASC(CASC)) u_resolve (
    .irr(irr_o), .imr(imr_q), .isr(isr_o), .base(base_o),
    .sfnm(cfg_sfnm), .master(cfg_master),
    .win_valid(win_valid), .win_idx(win_idx),
    .top_valid(top_valid), .top_idx(top_idx)
  );

  prio_irq_service #(.N(N)) u_service (
    .clk(clk), .rst_n(rst_n), .ack_take(ack_take), .win_idx(win_idx),
    .aeoi(cfg_aeoi), .rot_aeoi(cfg_rot_aeoi), .eoi_take(eoi_take),
    .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate), .eoi_sel(eoi_sel),
    .top_valid(top_valid), .top_idx(top_idx), .base_we(base_we),
    .base_wdata(base_wdata), .isr(isr_o), .base(base_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q   <= '0;
      irq_req <= 1'b0;
      irq_idx <= '0;
    end else begin
      if (mask_we) imr_q <= mask_wdata;
      irq_req <= win_valid;
      irq_idx <= win_valid ? win_idx : '0;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int unsigned N    = 8,
  parameter int unsigned CASC = 2,
  localparam int unsigned W   = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_lines,
  input logic [N-1:0] cfg_level,
  input logic         cfg_aeoi,
  input logic         cfg_sfnm,
  input logic         cfg_master,
  input logic         irq_ack,
  input logic         eoi_valid,
  input logic         base_we,
  input logic [N-1:0] irr_o,
  input logic [N-1:0] isr_o,
  input logic [W-1:0] base_o,
  input logic [N-1:0] imr_q,
  input logic         win_valid,
  input logic [W-1:0] win_idx,
  input logic         ack_take
);
  // R6: a winner is always an unmasked pending request
  assert_win_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (irr_o[win_idx] && !imr_q[win_idx]));

  // R5: outside fully nested master mode a winner is never already in service
  assert_win_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !(cfg_sfnm && cfg_master)) |-> !isr_o[win_idx]);

  // R3: level inputs mirror the line one clock later
  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((irr_o ^ $past(irq_lines)) & $past(cfg_level)) == '0));

  // R8: a taken acknowledge without auto EOI marks the winner in service
  assert_ack_sets_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ack_take) && !$past(cfg_aeoi)) |-> isr_o[$past(win_idx)]);

  // R9: with auto EOI an acknowledge leaves the in-service register alone
  assert_aeoi_isr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ack_take) && $past(cfg_aeoi)) |-> (isr_o == $past(isr_o)));

  // R10: acknowledge with nothing eligible changes no state
  assert_empty_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(irq_ack && !win_valid && !eoi_valid && !base_we))
      |-> ((isr_o == $past(isr_o)) && (base_o == $past(base_o))));
endmodule

bind prio_irq_core prio_irq_chk #(.N(N), .CASC(CASC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_level(cfg_level),
  .cfg_aeoi(cfg_aeoi), .cfg_sfnm(cfg_sfnm), .cfg_master(cfg_master),
  .irq_ack(irq_ack), .eoi_valid(eoi_valid), .base_we(base_we),
  .irr_o(irr_o), .isr_o(isr_o), .base_o(base_o), .imr_q(imr_q),
  .win_valid(win_valid), .win_idx(win_idx), .ack_take(ack_take)
);

// File: tb/sim_prio_irq_core.sv
module sim_prio_irq_core;
  localparam int PERIOD = 10;
  localparam int NI = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] lines = '0, level = '0, mask_d = '0;
  logic mask_we = 0, base_we = 0, ack = 0, eoi_v = 0, eoi_s = 0, eoi_r = 0;
  logic [2:0] base_d = '0, eoi_sel = '0;
  logic aeoi = 0, rot = 0, sfnm = 0, master = 0;
  logic irq_req;
  logic [2:0] irq_idx, base_o;
  logic [7:0] irr_o, isr_o;

  int n_checks = 0, n_fail = 0;
  logic [7:0] m_irr, m_isr, m_imr, m_last;
  logic [2:0] m_base, m_idx;
  logic m_req;

  always #(PERIOD/2) clk = ~clk;

  prio_irq_core u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .cfg_level(level),
    .cfg_aeoi(aeoi), .cfg_rot_aeoi(rot), .cfg_sfnm(sfnm), .cfg_master(master),
    .mask_we(mask_we), .mask_wdata(mask_d), .base_we(base_we), .base_wdata(base_d),
    .irq_ack(ack), .eoi_valid(eoi_v), .eoi_specific(eoi_s), .eoi_rotate(eoi_r),
    .eoi_sel(eoi_sel), .irq_req(irq_req), .irq_idx(irq_idx), .irr_o(irr_o),
    .isr_o(isr_o), .base_o(base_o)
  );

  function automatic int rank(int i, int b);
    return (i - b + NI) % NI;
  endfunction

  // index of best-ranked set bit, -1 if empty
  function automatic int best(logic [7:0] m, int b);
    int pick = -1;
    for (int i = 0; i < NI; i++)
      if (m[i] && (pick < 0 || rank(i, b) < rank(pick, b))) pick = i;
    return pick;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_irr = 0; m_isr = 0; m_imr = 0; m_last = 0; m_base = 0; m_req = 0; m_idx = 0;
  endtask

  task automatic model_tick();
    int c, t, b;
    logic [7:0] busy, nirr;
    logic ok;
    b = int'(m_base);
    c = best(m_irr & ~m_imr, b);
    busy = m_isr;
    if (sfnm && master) busy[2] = 1'b0;
    t = best(busy, b);
    ok = (c >= 0) && (t < 0 || rank(c, b) < rank(t, b));
    for (int i = 0; i < NI; i++)
      nirr[i] = level[i] ? lines[i] : (m_irr[i] | (lines[i] & ~m_last[i]));
    m_last = lines;
    if (ack && ok) begin
      if (!level[c]) nirr[c] = 1'b0;
      if (!aeoi) m_isr[c] = 1'b1;
      else if (rot) m_base = 3'((c + 1) % NI);
    end else if (eoi_v) begin
      t = eoi_s ? int'(eoi_sel) : best(m_isr, b);
      if (t >= 0) begin
        m_isr[t] = 1'b0;
        if (eoi_r) m_base = 3'((t + 1) % NI);
      end
    end
    m_irr = nirr;
    if (mask_we) m_imr = mask_d;
    if (base_we) m_base = base_d;
    m_req = ok;
    m_idx = ok ? 3'(c) : 3'd0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_tick();
    @(negedge clk);
    check({tag, " irq_req"}, int'(irq_req), int'(m_req));
    check({tag, " irq_idx"}, int'(irq_idx), int'(m_idx));
    check({tag, " irr"}, int'(irr_o), int'(m_irr));
    check({tag, " isr"}, int'(isr_o), int'(m_isr));
    check({tag, " base"}, int'(base_o), int'(m_base));
    ack = 0; eoi_v = 0; mask_we = 0; base_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 irq_req", int'(irq_req), 0);
    check("R1 irq_idx", int'(irq_idx), 0);
    check("R1 irr", int'(irr_o), 0);
    check("R1 isr", int'(isr_o), 0);
    check("R1 base", int'(base_o), 0);

    // R2 edge latch: low does not clear, no re-trigger without a low
    lines = 8'h10; step("R2");
    lines = 8'h00; step("R2");
    check("R2 held", int'(irr_o[4]), 1);
    lines = 8'h10; step("R2");
    // R8 ack on edge input clears the request, sets in-service
    ack = 1; step("R8");
    check("R8 irr cleared", int'(irr_o[4]), 0);
    check("R8 isr set", int'(isr_o[4]), 1);
    lines = 8'h00; step("R2");
    // R11 non-specific EOI with rotation
    eoi_v = 1; eoi_s = 0; eoi_r = 1; step("R11");
    check("R11 base", int'(base_o), 5);
    eoi_v = 1; step("R11 empty");

    // R3 level follows line; R8 ack keeps level request
    level = 8'h02; lines = 8'h02; step("R3");
    step("R3");
    ack = 1; step("R8");
    check("R8 level irr kept", int'(irr_o[1]), 1);
    lines = 8'h00; step("R3");
    check("R3 cleared", int'(irr_o[1]), 0);
    eoi_v = 1; eoi_s = 1; eoi_sel = 3'd1; eoi_r = 0; step("R12");
    check("R12 isr", int'(isr_o), 0);

    // R4 rotation: base 5, inputs 0 and 7 pending -> 7 wins
    do_reset();
    level = 0;
    base_we = 1; base_d = 3'd5; step("R4");
    lines = 8'h81; step("R4");
    step("R4");
    check("R4 idx", int'(irq_idx), 7);
    // R5 in-service blocks equal/lower rank
    ack = 1; step("R5");
    step("R5");
    check("R5 blocked", int'(irq_req), 0);
    // R6 mask hides input 0 even with isr cleared
    mask_we = 1; mask_d = 8'h01; eoi_v = 1; eoi_s = 0; eoi_r = 0; step("R6");
    step("R6");
    step("R6");
    check("R6 masked", int'(irq_req), 0);
    // R10 empty ack changes nothing
    ack = 1; step("R10");
    // R12 specific EOI with rotation
    mask_we = 1; mask_d = 8'h00; step("R12");
    ack = 1; step("R12");
    eoi_v = 1; eoi_s = 1; eoi_sel = 3'd0; eoi_r = 1; step("R12");
    check("R12 base", int'(base_o), 1);

    // R7 fully nested master: input 2 in service does not block input 2
    do_reset();
    sfnm = 1; master = 1; lines = 8'h04; step("R7");
    ack = 1; step("R7");
    lines = 8'h00; step("R7");
    lines = 8'h04; step("R7");
    step("R7");
    check("R7 req", int'(irq_req), 1);
    sfnm = 0; step("R7");
    step("R7");
    check("R7 off", int'(irq_req), 0);
    eoi_v = 1; eoi_s = 0; eoi_r = 0; step("R7");

    // R9 auto EOI with rotation
    aeoi = 1; rot = 1; step("R9");
    ack = 1; step("R9");
    check("R9 base", int'(base_o), 3);
    check("R9 isr", int'(isr_o), 0);
    aeoi = 0; rot = 0;

    // R13 ack beats EOI; base load beats rotation
    lines = 8'h20; step("R13");
    ack = 1; eoi_v = 1; eoi_s = 1; eoi_sel = 3'd5; eoi_r = 1; step("R13");
    check("R13 isr", int'(isr_o[5]), 1);
    eoi_v = 1; eoi_s = 1; eoi_sel = 3'd5; eoi_r = 1; base_we = 1; base_d = 3'd6;
    step("R13");
    check("R13 base", int'(base_o), 6);

    // R13 random mix against the bench model
    for (int k = 0; k < 4000; k++) begin
      if (k % 256 == 0) begin
        level = 8'($urandom); aeoi = 1'($urandom); rot = 1'($urandom);
        sfnm = 1'($urandom); master = 1'($urandom);
      end
      lines   = lines ^ (8'($urandom) & 8'($urandom));
      ack     = ($urandom % 4) == 0;
      eoi_v   = ($urandom % 6) == 0;
      eoi_s   = 1'($urandom);
      eoi_r   = 1'($urandom);
      eoi_sel = 3'($urandom);
      mask_we = ($urandom % 20) == 0;
      mask_d  = 8'($urandom) & 8'($urandom);
      base_we = ($urandom % 20) == 0;
      base_d  = 3'($urandom);
      step("R13 random");
    end
    finish_run();
  end
endmodule